// File: doc/BRIEF.md
# Scan Chain with Safe-Shift Forcing

This block is a short chain of mux-D scan flip-flops wrapped around a small piece of functional logic. It also contains the gating that makes shifting safe. In functional mode each cell captures the output of the logic cloud. In shift mode the cells form a serial path from `scan_in` to `scan_out`. The same shift clocks load the next test vector and unload the previously captured response. After the last shift clock, the loaded bits sit on the Q outputs and drive the logic cloud: this is the apply state. Lowering the scan enable while the clock is low lets the next rising edge capture the logic's response.

Three forcing controls guard shifting:
- A force enable blocks the asynchronous set and clear and forces the gated clock branch on.
- A separate tristate enable, whose timing may differ from the scan enable, forces the two drivers of an internal shared net into mutual exclusivity.
- A parameter selects whether an unblocked asynchronous set overrides shifting, or whether shifting masks the set.

The modes are functional capture (`scan_en`=0), shift (`scan_en`=1) and apply (the state after the last shift, before capture). There is no sequencer: the mode follows the enables directly.

Top module: `scan_safe_chain`

## Requirements
- R1: Capture. With `scan_en`=0 and the clock enabled, each rising edge loads every cell `q[i]` with its functional D input. The cloud computes `d[0] = func_in[0] ^ bus`, and `d[i] = func_in[i] ^ q[i-1]` for i>0.
- R2: Shift. With `scan_en`=1 and the clock enabled, each rising edge loads `q[0]` from `scan_in` and `q[i]` from `q[i-1]`.
- R3: `scan_out` always equals `q[LEN-1]`. While a new vector shifts in, the previous captured response leaves in the order `q[LEN-1]` first, down to `q[0]` last.
- R4: Apply. After LEN shift clocks in which bit `v[LEN-1]` is sent first and `v[0]` last, `q_out` equals `v`.
- R5: With `force_en`=0, raising `async_clr` clears every cell to 0 at once, without a clock. Clear wins over a set that is active at the same time.
- R6: With `force_en`=0 and the default set-first variant, raising `async_set` sets every cell to 1 at once, even while `scan_en`=1.
- R7: With `force_en`=1, `async_set` and `async_clr` have no effect, and shifting proceeds on the clock edge while they are held.
- R8: Cells sit behind a clock gate enabled by `func_ce`. With `func_ce`=0 and `force_en`=0 the cells hold; `force_en`=1 turns the clock on for shifting.
- R9: Shared net. Driver A drives `func_in[1]` when enabled, and driver B drives `func_in[2]`; the net value is `bus = (enA & func_in[1]) | (enB & func_in[2])`. Functionally, enA=`q[0]` and enB=`q[1]`. With `tri_en`=1, enA is forced to 1 and enB to 0, so `bus_out` equals `func_in[1]`.
- R10: In the shift-first variant (`PRI`=`PRI_SHIFT_FIRST`), `async_set` is ignored while `scan_en`=1, so shifting continues. It takes effect once `scan_en` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift and capture clock |
| async_set | input | 1 | Asynchronous set, active high |
| async_clr | input | 1 | Asynchronous clear, active high |
| func_ce | input | 1 | Functional enable of the gated clock branch |
| scan_en | input | 1 | Scan enable: 1 shift, 0 capture |
| force_en | input | 1 | Force: blocks set and clear, forces the clock on |
| tri_en | input | 1 | Tristate scan enable: forces the shared-net drivers exclusive |
| scan_in | input | 1 | Serial data into cell 0 |
| func_in | input | LEN | Functional data inputs to the logic cloud |
| q_out | output | LEN | Q outputs of the cells |
| scan_out | output | 1 | Serial data out, Q of the last cell |
| bus_out | output | 1 | Value of the internal shared net |

## Verification
A wrong cell value shows on `q_out` one nanosecond after the offending edge, and on `scan_out` during the next unload. A wrong mux select or a broken chain link therefore appears as a mismatch within one vector. A leak in the set or clear blocking shows immediately, because asynchronous effects are sampled before any clock edge. A missing clock override appears as a frozen `q_out` after a single shift edge. A failure to force the shared-net drivers appears as the wrong `bus_out` value during shift.

// File: rtl/scan_safe_pkg.sv
package scan_safe_pkg;

    // Priority between an unblocked asynchronous set and scan shifting
    typedef enum logic {
        PRI_SET_FIRST   = 1'b0,
        PRI_SHIFT_FIRST = 1'b1
    } async_pri_e;

endpackage

// File: rtl/safe_force_ctrl.sv
module safe_force_ctrl
    import scan_safe_pkg::*;
#(
    parameter async_pri_e PRI = PRI_SET_FIRST
) (
    input  logic async_set,
    input  logic async_clr,
    input  logic func_ce,
    input  logic scan_en,
    input  logic force_en,
    output logic set_eff,
    output logic clr_eff,
    output logic ce_eff
);

    logic set_masked;

    generate
        if (PRI == PRI_SHIFT_FIRST) begin : g_shift_first
            assign set_masked = async_set & ~scan_en;
        end else begin : g_set_first
            assign set_masked = async_set;
        end
    endgenerate

    always_comb begin
        set_eff = set_masked & ~force_en;
        clr_eff = async_clr & ~force_en;
        ce_eff  = func_ce | force_en;
    end

endmodule

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic set_a,
    input  logic clr_a,
    input  logic ce,
    input  logic se,
    input  logic d,
    input  logic sdi,
    output logic q
);

    always_ff @(posedge clk or posedge clr_a or posedge set_a) begin
        if (clr_a) begin
            q <= 1'b0;
        end else if (set_a) begin
            q <= 1'b1;
        end else if (ce) begin
            q <= se ? sdi : d;
        end
    end

    assert_capture_R1: assert property (@(posedge clk) disable iff (set_a || clr_a)
        (ce && !se) |=> (q == $past(d)));

    assert_shift_R2: assert property (@(posedge clk) disable iff (set_a || clr_a)
        (ce && se) |=> (q == $past(sdi)));

    assert_gate_hold_R8: assert property (@(posedge clk) disable iff (set_a || clr_a)
        !ce |=> $stable(q));

endmodule

// File: rtl/func_cloud.sv
module func_cloud #(
    parameter int LEN = 4
) (
    input  logic           clk,
    input  logic           clr_a,
    input  logic           tri_force,
    input  logic [LEN-1:0] q,
    input  logic [LEN-1:0] func_in,
    output logic [LEN-1:0] d,
    output logic           bus
);

    logic en_a;
    logic en_b;

    // Drivers of the shared net; forced exclusive while tri_force is high
    always_comb begin
        en_a = tri_force ? 1'b1 : q[0];
        en_b = tri_force ? 1'b0 : q[1];
        bus  = (en_a & func_in[1]) | (en_b & func_in[2]);
    end

    genvar i;
    generate
        for (i = 0; i < LEN; i++) begin : g_d
            if (i == 0) begin : g_head
                assign d[i] = func_in[i] ^ bus;
            end else begin : g_body
                assign d[i] = func_in[i] ^ q[i-1];
            end
        end
    endgenerate

    assert_tri_excl_R9: assert property (@(posedge clk) disable iff (clr_a)
        tri_force |-> !(en_a && en_b));

endmodule

// File: rtl/scan_safe_chain.sv
module scan_safe_chain
    import scan_safe_pkg::*;
#(
    parameter int         LEN = 4,
    parameter async_pri_e PRI = PRI_SET_FIRST
) (
    input  logic           clk,
    input  logic           async_set,
    input  logic           async_clr,
    input  logic           func_ce,
    input  logic           scan_en,
    input  logic           force_en,
    input  logic           tri_en,
    input  logic           scan_in,
    input  logic [LEN-1:0] func_in,
    output logic [LEN-1:0] q_out,
    output logic           scan_out,
    output logic           bus_out
);

    localparam int LAST = LEN - 1;

    logic           set_eff;
    logic           clr_eff;
    logic           ce_eff;
    logic [LEN-1:0] q;
    logic [LEN-1:0] d;

    initial begin
        if (LEN < 3) $error("LEN must be at least 3");
    end

    safe_force_ctrl #(.PRI(PRI)) u_force (
        .async_set (async_set),
        .async_clr (async_clr),
        .func_ce   (func_ce),
        .scan_en   (scan_en),
        .force_en  (force_en),
        .set_eff   (set_eff),
        .clr_eff   (clr_eff),
        .ce_eff    (ce_eff)
    );

    func_cloud #(.LEN(LEN)) u_cloud (
        .clk       (clk),
        .clr_a     (clr_eff),
        .tri_force (tri_en),
        .q         (q),
        .func_in   (func_in),
        .d         (d),
        .bus       (bus_out)
    );

    genvar i;
    generate
        for (i = 0; i < LEN; i++) begin : g_cell
            logic sdi;
            if (i == 0) begin : g_first
                assign sdi = scan_in;
            end else begin : g_next
                assign sdi = q[i-1];
            end
            scan_cell u_cell (
                .clk   (clk),
                .set_a (set_eff),
                .clr_a (clr_eff),
                .ce    (ce_eff),
                .se    (scan_en),
                .d     (d[i]),
                .sdi   (sdi),
                .q     (q[i])
            );
        end
    endgenerate

    assign q_out    = q;
    assign scan_out = q[LAST];

    assert_force_shift_R7: assert property (@(posedge clk) disable iff (set_eff || clr_eff)
        (scan_en && force_en) |=> (q_out == {$past(q_out[LEN-2:0]), $past(scan_in)}));

    assert_scan_out_R3: assert property (@(posedge clk) disable iff (clr_eff)
        scan_out == q_out[LAST]);

endmodule

// File: tb/tb_scan_safe_chain.sv
module tb_scan_safe_chain;
    import scan_safe_pkg::*;

    localparam int L = 4;

    logic         clk = 1'b0;
    logic         async_set = 1'b0;
    logic         async_clr = 1'b1;
    logic         func_ce = 1'b0;
    logic         scan_en = 1'b0;
    logic         force_en = 1'b0;
    logic         tri_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [L-1:0] func_in = '0;
    logic [L-1:0] q_out, q_v;
    logic         scan_out, scan_out_v, bus_out, bus_v;

    int n_cmp = 0;
    int n_bad = 0;
    logic [L-1:0] mq;

    always #2 clk = ~clk;

    scan_safe_chain #(.LEN(L), .PRI(PRI_SET_FIRST)) dut (
        .clk(clk), .async_set(async_set), .async_clr(async_clr), .func_ce(func_ce),
        .scan_en(scan_en), .force_en(force_en), .tri_en(tri_en), .scan_in(scan_in),
        .func_in(func_in), .q_out(q_out), .scan_out(scan_out), .bus_out(bus_out)
    );

    scan_safe_chain #(.LEN(L), .PRI(PRI_SHIFT_FIRST)) dut_v (
        .clk(clk), .async_set(async_set), .async_clr(async_clr), .func_ce(func_ce),
        .scan_en(scan_en), .force_en(force_en), .tri_en(tri_en), .scan_in(scan_in),
        .func_in(func_in), .q_out(q_v), .scan_out(scan_out_v), .bus_out(bus_v)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic model_bus(input logic [L-1:0] q, input logic [L-1:0] fi);
        return (q[0] & fi[1]) | (q[1] & fi[2]);
    endfunction

    function automatic logic [L-1:0] model_next(input logic [L-1:0] q, input logic [L-1:0] fi);
        logic [L-1:0] r;
        r[0] = fi[0] ^ model_bus(q, fi);
        for (int i = 1; i < L; i++) r[i] = fi[i] ^ q[i-1];
        return r;
    endfunction

    // One forced shift clock
    task automatic shift_bit(input logic b, input logic [L-1:0] fi);
        @(negedge clk);
        scan_en = 1'b1; force_en = 1'b1; tri_en = 1'b1; func_ce = 1'b0;
        scan_in = b; func_in = fi;
        @(posedge clk); #1;
        mq = {mq[L-2:0], b};
    endtask

    // Load nv while unloading and checking the previous response
    task automatic load_unload(input logic [L-1:0] nv, input logic [L-1:0] fi, input bit chk_out);
        for (int k = L - 1; k >= 0; k--) begin
            if (chk_out) chk("R3 unload bit", scan_out, mq[L-1]);
            shift_bit(nv[k], fi);
        end
        chk("R9 forced bus during shift", bus_out, fi[1]);
        chk("R4 apply vector", q_out, nv);
        chk("R2 chain state", q_out, mq);
    endtask

    task automatic capture(input logic [L-1:0] fi);
        @(negedge clk);
        scan_en = 1'b0; force_en = 1'b0; tri_en = 1'b0; func_ce = 1'b1; func_in = fi;
        #1;
        chk("R9 functional bus", bus_out, model_bus(mq, fi));
        @(posedge clk); #1;
        mq = model_next(mq, fi);
        chk("R1 capture", q_out, mq);
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk("R5 reset clear", q_out, '0);
        @(negedge clk);
        async_clr = 1'b0;
        mq = '0;
        @(posedge clk); #1;
        chk("R5 reset state hold", q_out, '0);
    endtask

    task automatic t_vectors();
        load_unload(4'b1011, 4'b0110, 1'b0);
        capture(4'b0101);
        load_unload(4'b0110, 4'b1100, 1'b1);
        capture(4'b1110);
        load_unload(4'b1111, 4'b0010, 1'b1);
        capture(4'b0011);
        load_unload(4'b0000, 4'b1001, 1'b1);
    endtask

    task automatic t_clock_gate();
        load_unload(4'b0110, 4'b0000, 1'b0);
        @(negedge clk);
        scan_en = 1'b1; force_en = 1'b0; func_ce = 1'b0; scan_in = 1'b1;
        @(posedge clk); #1;
        chk("R8 gated shift holds", q_out, 4'b0110);
        @(negedge clk);
        scan_en = 1'b0;
        @(posedge clk); #1;
        chk("R8 gated capture holds", q_out, 4'b0110);
        @(negedge clk);
        scan_en = 1'b1; force_en = 1'b1;
        @(posedge clk); #1;
        chk("R8 forced clock shifts", q_out, 4'b1101);
        mq = 4'b1101;
    endtask

    task automatic t_async();
        @(negedge clk);
        scan_en = 1'b1; force_en = 1'b1; func_ce = 1'b0; scan_in = 1'b0;
        async_clr = 1'b1; async_set = 1'b1;
        #1;
        chk("R7 blocked set and clear", q_out, 4'b1101);
        @(posedge clk); #1;
        chk("R7 shift under blocking", q_out, 4'b1010);
        @(negedge clk);
        async_clr = 1'b0; async_set = 1'b0; scan_en = 1'b0; force_en = 1'b0;
        #1;
        chk("R7 state after release", q_out, 4'b1010);
        @(negedge clk);
        async_clr = 1'b1;
        #1;
        chk("R5 unblocked clear", q_out, 4'b0000);
        @(posedge clk);
        @(negedge clk);
        async_clr = 1'b0; async_set = 1'b1;
        #1;
        chk("R6 unblocked set", q_out, 4'b1111);
        @(posedge clk);
        @(negedge clk);
        async_clr = 1'b1;
        #1;
        chk("R5 clear over set", q_out, 4'b0000);
        @(posedge clk);
        @(negedge clk);
        async_clr = 1'b0; async_set = 1'b0;
        mq = '0;
        @(posedge clk); #1;
        chk("R5 stays clear", q_out, 4'b0000);
    endtask

    task automatic t_variant();
        load_unload(4'b0101, 4'b0000, 1'b0);
        chk("R10 variant loaded", q_v, 4'b0101);
        @(negedge clk);
        scan_en = 1'b1; force_en = 1'b0; tri_en = 1'b1; func_ce = 1'b1; scan_in = 1'b0;
        async_set = 1'b1;
        #1;
        chk("R6 set wins during shift", q_out, 4'b1111);
        chk("R10 set masked during shift", q_v, 4'b0101);
        @(posedge clk); #1;
        chk("R10 shift continues", q_v, 4'b1010);
        chk("R6 set held", q_out, 4'b1111);
        @(negedge clk);
        scan_en = 1'b0;
        #1;
        chk("R10 set after shift ends", q_v, 4'b1111);
        @(posedge clk);
        @(negedge clk);
        async_set = 1'b0;
        mq = 4'b1111;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        mq = '0;
        t_reset();
        t_vectors();
        t_clock_gate();
        t_async();
        t_variant();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule